// File: doc/BRIEF.md
# Two-Level Instruction Control Decoder

This block turns the opcode and function fields of a 32-bit three-format instruction into the control lines that steer a single-cycle datapath. It is purely combinational and has no state. The first level, the main decoder, looks only at the 6-bit opcode. From it the main decoder produces these outputs:

- the register-file write strobe and the destination-field select,
- the ALU second-operand select and the immediate extension mode,
- the memory write strobe and the write-back source select,
- a 2-bit ALU class code.

The second level, the ALU decoder, turns that class code into a 4-bit ALU operation. It reads the function field only when the class code says the instruction is register-register.

The next-PC select is formed from the branch opcode and the equality flag that the ALU returns for the current instruction. The select tells the fetch logic to take the branch target instead of PC + 4. The block is used between the instruction word and the datapath muxes, with one pass through the decoder for each instruction.

Top module: `ctl_decoder`

## Requirements
- R1: Opcode encodings: 000000 register-register, 100011 load word, 101011 store word, 000100 branch-if-equal, 001101 OR-immediate. Every other opcode is unrecognized.
- R2: `alu_class_o` is 10 for register-register, 01 for branch-if-equal, 11 for OR-immediate, and 00 for load, store and unrecognized opcodes.
- R3: For class 00, `alu_op_o` is 0010 (add). For class 01 it is 0110 (subtract). For class 11 it is 0001 (OR). In these cases the function field has no effect.
- R4: For class 10, function 100000 or 100001 gives 0010 (add). Function 100010 or 100011 gives 0110 (subtract). 100100 gives 0000 (AND), 100101 gives 0001 (OR), 101010 gives 0111 (set-less-than) and 100111 gives 1100 (NOR). Any other function value gives 0010.
- R5: `alu_src_imm_o` is 0 for register-register and 1 for every other opcode.
- R6: `ext_sign_o` is 0 (zero extension) for OR-immediate and 1 (sign extension) for every other opcode.
- R7: `mem_wr_o` is 1 only for store. `wb_from_mem_o` is 1 only for load.
- R8: `reg_wr_o` is 1 for register-register, load and OR-immediate. It is 0 for store, branch and unrecognized opcodes.
- R9: `dst_is_rd_o` is 0 (rt field) for load and OR-immediate, and 1 (rd field) for every other opcode.
- R10: `take_branch_o` equals `alu_eq_i` when the opcode is branch-if-equal, and is 0 for every other opcode.
- R11: The function field changes no output when the opcode is not register-register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 6 | Instruction opcode field |
| funct_i | input | 6 | Instruction function field |
| alu_eq_i | input | 1 | Equality flag from the ALU |
| dst_is_rd_o | output | 1 | 1: write rd field, 0: write rt field |
| alu_src_imm_o | output | 1 | 1: ALU operand B is the extended immediate |
| ext_sign_o | output | 1 | 1: sign-extend the immediate, 0: zero-extend it |
| wb_from_mem_o | output | 1 | 1: write-back data comes from memory |
| mem_wr_o | output | 1 | Data memory write strobe |
| reg_wr_o | output | 1 | Register file write strobe |
| take_branch_o | output | 1 | 1: next PC is the branch target |
| alu_class_o | output | 2 | First-level ALU class code |
| alu_op_o | output | 4 | Second-level ALU operation code |

## Verification
Each recognized opcode is driven with a function value chosen to mimic a register-register operation other than add. This separates a decoder that wrongly reads the function field for load, store, branch or OR-immediate from a correct one. Register-register instructions walk every listed function code plus one unlisted value, which checks that the second level maps each code and falls back to add. Branch-if-equal is driven with the equality flag both high and low, and the flag is also held high under other opcodes, so a select that ignores the opcode shows up. A sweep over all 64 opcodes confirms that the memory write, register write and branch strobes stay low for unrecognized codes.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int OP_W    = 6;
  localparam int FN_W    = 6;
  localparam int CLASS_W = 2;
  localparam int ALUOP_W = 4;

  localparam logic [OP_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OPC_ORI   = 6'b001101;

  typedef enum logic [CLASS_W-1:0] {
    CLS_MEM  = 2'b00,
    CLS_CMP  = 2'b01,
    CLS_REG  = 2'b10,
    CLS_OR   = 2'b11
  } alu_class_e;

  localparam logic [ALUOP_W-1:0] ALU_AND = 4'b0000;
  localparam logic [ALUOP_W-1:0] ALU_OR  = 4'b0001;
  localparam logic [ALUOP_W-1:0] ALU_ADD = 4'b0010;
  localparam logic [ALUOP_W-1:0] ALU_SUB = 4'b0110;
  localparam logic [ALUOP_W-1:0] ALU_SLT = 4'b0111;
  localparam logic [ALUOP_W-1:0] ALU_NOR = 4'b1100;

  typedef struct packed {
    logic       dst_is_rd;
    logic       alu_src_imm;
    logic       ext_sign;
    logic       wb_from_mem;
    logic       mem_wr;
    logic       reg_wr;
    logic       is_beq;
    alu_class_e alu_class;
  } main_ctl_t;
endpackage

// File: rtl/ctl_main_dec.sv
module ctl_main_dec
  import ctl_pkg::*;
(
  input  logic [OP_W-1:0] opcode_i,
  output main_ctl_t       ctl_o
);
  always_comb begin
    // unrecognized opcode: no writes, sequential PC
    ctl_o = '{dst_is_rd: 1'b1, alu_src_imm: 1'b1, ext_sign: 1'b1,
              wb_from_mem: 1'b0, mem_wr: 1'b0, reg_wr: 1'b0,
              is_beq: 1'b0, alu_class: CLS_MEM};
    unique case (opcode_i)
      OPC_RTYPE: begin
        ctl_o.alu_src_imm = 1'b0;
        ctl_o.reg_wr      = 1'b1;
        ctl_o.alu_class   = CLS_REG;
      end
      OPC_LOAD: begin
        ctl_o.dst_is_rd   = 1'b0;
        ctl_o.wb_from_mem = 1'b1;
        ctl_o.reg_wr      = 1'b1;
      end
      OPC_STORE: ctl_o.mem_wr = 1'b1;
      OPC_BEQ: begin
        ctl_o.is_beq    = 1'b1;
        ctl_o.alu_class = CLS_CMP;
      end
      OPC_ORI: begin
        ctl_o.dst_is_rd = 1'b0;
        ctl_o.ext_sign  = 1'b0;
        ctl_o.reg_wr    = 1'b1;
        ctl_o.alu_class = CLS_OR;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ctl_alu_dec.sv
module ctl_alu_dec
  import ctl_pkg::*;
(
  input  alu_class_e         alu_class_i,
  input  logic [FN_W-1:0]    funct_i,
  output logic [ALUOP_W-1:0] alu_op_o
);
  logic [ALUOP_W-1:0] fn_op;

  always_comb begin
    unique case (funct_i)
      6'b100000, 6'b100001: fn_op = ALU_ADD;
      6'b100010, 6'b100011: fn_op = ALU_SUB;
      6'b100100:            fn_op = ALU_AND;
      6'b100101:            fn_op = ALU_OR;
      6'b101010:            fn_op = ALU_SLT;
      6'b100111:            fn_op = ALU_NOR;
      default:              fn_op = ALU_ADD;
    endcase
  end

  always_comb begin
    unique case (alu_class_i)
      CLS_REG: alu_op_o = fn_op;
      CLS_CMP: alu_op_o = ALU_SUB;
      CLS_OR:  alu_op_o = ALU_OR;
      default: alu_op_o = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/ctl_pc_sel.sv
module ctl_pc_sel (
  input  logic is_beq_i,
  input  logic alu_eq_i,
  output logic take_branch_o
);
  assign take_branch_o = is_beq_i & alu_eq_i;
endmodule

// File: rtl/ctl_decoder.sv
module ctl_decoder
  import ctl_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  input  logic       alu_eq_i,
  output logic       dst_is_rd_o,
  output logic       alu_src_imm_o,
  output logic       ext_sign_o,
  output logic       wb_from_mem_o,
  output logic       mem_wr_o,
  output logic       reg_wr_o,
  output logic       take_branch_o,
  output logic [1:0] alu_class_o,
  output logic [3:0] alu_op_o
);
  main_ctl_t main_ctl;

  ctl_main_dec u_main (
    .opcode_i (opcode_i),
    .ctl_o    (main_ctl)
  );

  ctl_alu_dec u_alu (
    .alu_class_i (main_ctl.alu_class),
    .funct_i     (funct_i),
    .alu_op_o    (alu_op_o)
  );

  ctl_pc_sel u_pc (
    .is_beq_i      (main_ctl.is_beq),
    .alu_eq_i      (alu_eq_i),
    .take_branch_o (take_branch_o)
  );

  assign dst_is_rd_o   = main_ctl.dst_is_rd;
  assign alu_src_imm_o = main_ctl.alu_src_imm;
  assign ext_sign_o    = main_ctl.ext_sign;
  assign wb_from_mem_o = main_ctl.wb_from_mem;
  assign mem_wr_o      = main_ctl.mem_wr;
  assign reg_wr_o      = main_ctl.reg_wr;
  assign alu_class_o   = main_ctl.alu_class;
endmodule

// File: rtl/ctl_decoder_chk.sv
module ctl_decoder_chk (
  input logic [5:0] opcode_i,
  input logic       alu_eq_i,
  input logic       alu_src_imm_o,
  input logic       wb_from_mem_o,
  input logic       mem_wr_o,
  input logic       reg_wr_o,
  input logic       take_branch_o,
  input logic [1:0] alu_class_o,
  input logic [3:0] alu_op_o
);
  always_comb begin
    a_r10_branch_needs_eq: assert (!take_branch_o || (alu_eq_i && opcode_i == 6'b000100));
    a_r7_store_no_regwrite: assert (!mem_wr_o || (!reg_wr_o && !wb_from_mem_o));
    a_r3_cmp_is_sub: assert (alu_class_o != 2'b01 || alu_op_o == 4'b0110);
    a_r3_or_class: assert (alu_class_o != 2'b11 || alu_op_o == 4'b0001);
    a_r5_reg_class_uses_regb: assert ((alu_class_o == 2'b10) == !alu_src_imm_o);
    a_r8_load_writes: assert (!wb_from_mem_o || reg_wr_o);
  end
endmodule

bind ctl_decoder ctl_decoder_chk u_chk (
  .opcode_i      (opcode_i),
  .alu_eq_i      (alu_eq_i),
  .alu_src_imm_o (alu_src_imm_o),
  .wb_from_mem_o (wb_from_mem_o),
  .mem_wr_o      (mem_wr_o),
  .reg_wr_o      (reg_wr_o),
  .take_branch_o (take_branch_o),
  .alu_class_o   (alu_class_o),
  .alu_op_o      (alu_op_o)
);

// File: tb/ctl_decoder_tb_top.sv
`timescale 1ns/1ps
module ctl_decoder_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [5:0] opcode = 6'b0;
  logic [5:0] funct  = 6'b0;
  logic       eq     = 1'b0;
  logic dst_is_rd, alu_src_imm, ext_sign, wb_from_mem, mem_wr, reg_wr, take_branch;
  logic [1:0] alu_class;
  logic [3:0] alu_op;

  int n_chk = 0;
  int n_bad = 0;

  ctl_decoder dut_i (
    .opcode_i      (opcode),
    .funct_i       (funct),
    .alu_eq_i      (eq),
    .dst_is_rd_o   (dst_is_rd),
    .alu_src_imm_o (alu_src_imm),
    .ext_sign_o    (ext_sign),
    .wb_from_mem_o (wb_from_mem),
    .mem_wr_o      (mem_wr),
    .reg_wr_o      (reg_wr),
    .take_branch_o (take_branch),
    .alu_class_o   (alu_class),
    .alu_op_o      (alu_op)
  );

  // {opcode, funct, eq, rd, imm, sext, wbmem, mwr, rwr, br, class[2], op[4]}
  localparam int NV = 18;
  localparam logic [25:0] VEC [NV] = '{
    {6'b000000, 6'b100001, 1'b0, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0, 2'b10, 4'b0010}, // R4 addu
    {6'b000000, 6'b100011, 1'b1, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0, 2'b10, 4'b0110}, // R4 subu, R10 eq ignored
    {6'b000000, 6'b100000, 1'b0, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0, 2'b10, 4'b0010}, // R4 add
    {6'b000000, 6'b100010, 1'b0, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0, 2'b10, 4'b0110}, // R4 sub
    {6'b000000, 6'b100100, 1'b0, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0, 2'b10, 4'b0000}, // R4 and
    {6'b000000, 6'b100101, 1'b0, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0, 2'b10, 4'b0001}, // R4 or
    {6'b000000, 6'b101010, 1'b0, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0, 2'b10, 4'b0111}, // R4 slt
    {6'b000000, 6'b100111, 1'b0, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0, 2'b10, 4'b1100}, // R4 nor
    {6'b000000, 6'b111111, 1'b0, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0, 2'b10, 4'b0010}, // R4 unlisted
    {6'b100011, 6'b100100, 1'b1, 1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0, 2'b00, 4'b0010}, // R7 R9 R11 load
    {6'b100011, 6'b000000, 1'b0, 1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0, 2'b00, 4'b0010}, // R7 load
    {6'b101011, 6'b100010, 1'b0, 1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0, 2'b00, 4'b0010}, // R7 R8 R11 store
    {6'b101011, 6'b100111, 1'b1, 1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0, 2'b00, 4'b0010}, // R10 store eq
    {6'b000100, 6'b100101, 1'b1, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 2'b01, 4'b0110}, // R10 beq taken
    {6'b000100, 6'b100100, 1'b0, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 2'b01, 4'b0110}, // R10 beq not taken
    {6'b001101, 6'b100010, 1'b1, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 2'b11, 4'b0001}, // R6 R2 ori
    {6'b001101, 6'b101010, 1'b0, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 2'b11, 4'b0001}, // R11 ori
    {6'b111111, 6'b100010, 1'b1, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 2'b00, 4'b0010}  // R1 R8 unrecognized
  };

  function automatic logic [12:0] outs();
    return {dst_is_rd, alu_src_imm, ext_sign, wb_from_mem, mem_wr, reg_wr,
            take_branch, alu_class, alu_op};
  endfunction

  task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b (op=%b fn=%b eq=%b)", req, act, exp, opcode, funct, eq);
    end
  endtask

  task automatic apply(input logic [5:0] op, input logic [5:0] fn, input logic e);
    @(posedge clk);
    opcode = op; funct = fn; eq = e;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    // initial state: all-zero inputs decode as register-register with add
    #1;
    check("R1 R4 initial", outs(), {1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,2'b10,4'b0010});

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][25:20], VEC[i][19:14], VEC[i][13]);
      check("R1-vector", outs(), VEC[i][12:0]);
    end

    // R11: function sweep under OR-immediate keeps every output fixed
    for (int f = 0; f < 64; f++) begin
      apply(6'b001101, 6'(f), 1'b0);
      check("R11 ori funct sweep", outs(), {1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,2'b11,4'b0001});
    end

    // R8 R10 R7: opcode sweep with eq high
    for (int o = 0; o < 64; o++) begin
      logic [5:0] op;
      logic       x_mwr, x_rwr, x_br;
      op = 6'(o);
      x_mwr = (op == 6'b101011);
      x_rwr = (op == 6'b000000) || (op == 6'b100011) || (op == 6'b001101);
      x_br  = (op == 6'b000100);
      apply(op, 6'b100101, 1'b1);
      check("R8 R10 R7 strobes", {10'b0, mem_wr, reg_wr, take_branch}, {10'b0, x_mwr, x_rwr, x_br});
      check("R5 R6 selects", {11'b0, alu_src_imm, ext_sign},
            {11'b0, op != 6'b000000, op != 6'b001101});
    end

    // R9: destination select back-to-back transitions
    apply(6'b001101, 6'b0, 1'b0);
    check("R9 ori rt", {12'b0, dst_is_rd}, 13'b0);
    apply(6'b000000, 6'b0, 1'b0);
    check("R9 rtype rd", {12'b0, dst_is_rd}, 13'b1);
    // R3 branch class ignores funct set to and
    apply(6'b000100, 6'b100100, 1'b0);
    check("R3 R2 beq sub", {7'b0, alu_class, alu_op}, {7'b0, 2'b01, 4'b0110});

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule